// File: doc/BRIEF.md
# SDRAM Single-Row Burst Read Sequencer

This block serves read requests of one to several words that all lie in one row of one SDRAM bank. A host presents a bank, row, starting column and word count together with a valid strobe. The block accepts the request only while it is idle. It then drives a fixed command sequence on the SDRAM control pins. First it closes the bank, then it opens the requested row, then it issues as many READ commands as the programmed burst length requires. Every gap between commands is filled with NOP.

The returned words are sampled from the DQ bus after the CAS latency and handed to the host one per cycle with a valid strobe. When the programmed burst is shorter than the request, the block chains READ commands so that the bursts arrive back to back. When the burst is longer than the request, the beats past the last wanted word are dropped. A single-cycle done pulse closes each transfer.

Top module: `sdram_burst_reader`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, the command on the pins is NOP, `rd_valid` and `done` are 0, `sd_dqm` is all ones and `sd_cke` is 1.
- R2: A request is taken at a clock edge only when `req_valid` is 1, `req_ready` is 1 and `req_len` is nonzero. A request with `req_len` of zero, or any request presented while busy, leaves the command stream and outputs unchanged.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP=0111, ACTIVATE=0011, READ=0101 and PRECHARGE=0010. In the cycle after acceptance the block drives PRECHARGE with address bit 10 high and the request bank. ACTIVATE follows T_RP cycles later with the row on the address pins and the bank. Every other cycle carries NOP, except the READ slots of R5.
- R4: `burst_sel` is sampled at acceptance and selects the burst length: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. The number of READ commands per request is the word count divided by the burst length, rounded up.
- R5: The first READ comes T_RP+T_RCD cycles after PRECHARGE. Further READs follow at offsets that are multiples of the burst length, for as long as the offset is below the word count. Each READ carries the bank and the column start+offset on the low address bits, with address bit 10 low (no auto-precharge).
- R6: Word i (counting from 0) is sampled from `sd_dq_in` at the edge that lies CAS_LAT edges after the edge registering READ offset i. It is shown on `rd_data` with `rd_valid` high in cycle T_RP+T_RCD+1+CAS_LAT+i after acceptance, which is cycle 7+i with the defaults.
- R7: `rd_valid` is high for exactly `req_len` cycles per request. Surplus beats from a burst longer than the request are never reported.
- R8: `done` pulses for one cycle, one cycle after the last wanted word was shown. `req_ready` returns high in that same cycle.
- R9: `sd_dqm` is all zeros from acceptance until the block is idle again and all ones while idle. `sd_cke` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | High while idle and able to accept |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Column of the first word |
| req_len | input | LEN_W | Number of words wanted |
| burst_sel | input | 2 | Programmed burst length code |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| sd_dqm | output | DQM_W | Byte masks |
| sd_dq_in | input | DQ_W | Data returned by the SDRAM |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | DQ_W | Captured word |
| done | output | 1 | Transfer complete pulse |

## Verification
All timing is counted from the acceptance edge, taken as cycle 0. PRECHARGE is due in cycle 0, ACTIVATE in cycle 2, READs from cycle 4 at steps of the burst length, word i in cycle 7+i, and done together with the return of ready in cycle 7+len. The bench drives and samples on the falling edge. For every cycle of a transfer window that runs past the done cycle, it compares pins, data, valid, done, ready and masks against a schedule computed from these offsets. Its SDRAM model latches each READ on the falling edge and queues the beats for the edges CAS latency later. Surplus beats and ignored requests therefore show up as a mismatch at the ports.

// File: rtl/sdbr_pkg.sv
package sdbr_pkg;

  typedef enum logic [1:0] {
    C_NOP  = 2'd0,
    C_PRE  = 2'd1,
    C_ACT  = 2'd2,
    C_READ = 2'd3
  } sd_cmd_e;

  // Burst length code: 00->1, 01->2, 10->4, 11->8
  function automatic logic [3:0] burst_words(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(input sd_cmd_e c);
    case (c)
      C_PRE:   return 4'b0010;
      C_ACT:   return 4'b0011;
      C_READ:  return 4'b0101;
      default: return 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/sdbr_pins.sv
module sdbr_pins
  import sdbr_pkg::*;
(
  input  sd_cmd_e cmd,
  output logic    cs_n,
  output logic    ras_n,
  output logic    cas_n,
  output logic    we_n
);
  always_comb {cs_n, ras_n, cas_n, we_n} = cmd_pins(cmd);
endmodule

// File: rtl/sdbr_ctrl.sv
module sdbr_ctrl
  import sdbr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int LEN_W  = 6,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        burst_sel,
  input  logic              fin,
  output logic              req_ready,
  output sd_cmd_e           cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              want,
  output logic              last
);
  localparam int TMAX  = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TMR_W = (TMAX > 1) ? $clog2(TMAX + 1) : 1;
  localparam logic [TMR_W-1:0] RP_LOAD  = TMR_W'((T_RP > 1) ? T_RP - 2 : 0);
  localparam logic [TMR_W-1:0] RCD_LOAD = TMR_W'((T_RCD > 1) ? T_RCD - 2 : 0);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_WRP, S_ACT, S_WRCD, S_RD, S_DRAIN} st_e;

  st_e               state;
  logic [TMR_W-1:0]  tmr;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [LEN_W-1:0]  len_q, bl_q, beat;

  // Column of a READ at a given beat offset
  function automatic logic [COL_W-1:0] read_col(input logic [COL_W-1:0] c,
                                                input logic [LEN_W-1:0] off);
    return c + COL_W'(off);
  endfunction

  logic accept, last_beat, read_slot;
  assign accept    = req_valid && (state == S_IDLE) && (req_len != '0);
  assign last_beat = (beat == len_q - 1'b1);
  assign read_slot = ((beat & (bl_q - 1'b1)) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; tmr <= '0; bank_q <= '0; row_q <= '0;
      col_q <= '0; len_q <= '0; bl_q <= '0; beat <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          bank_q <= req_bank; row_q <= req_row; col_q <= req_col;
          len_q  <= req_len;  bl_q  <= LEN_W'(burst_words(burst_sel));
          beat   <= '0;       state <= S_PRE;
        end
        S_PRE: begin
          tmr   <= RP_LOAD;
          state <= (T_RP > 1) ? S_WRP : S_ACT;
        end
        S_WRP:  if (tmr == '0) state <= S_ACT; else tmr <= tmr - 1'b1;
        S_ACT: begin
          tmr   <= RCD_LOAD;
          state <= (T_RCD > 1) ? S_WRCD : S_RD;
        end
        S_WRCD: if (tmr == '0) state <= S_RD; else tmr <= tmr - 1'b1;
        S_RD: begin
          beat <= beat + 1'b1;
          if (last_beat) state <= S_DRAIN;
        end
        S_DRAIN: if (fin) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = '0;
    addr = '0;
    case (state)
      S_PRE: begin cmd = C_PRE; ba = bank_q; addr[10] = 1'b1; end
      S_ACT: begin cmd = C_ACT; ba = bank_q; addr = ADDR_W'(row_q); end
      S_RD: if (read_slot) begin
        cmd = C_READ; ba = bank_q; addr = ADDR_W'(read_col(col_q, beat));
      end
      default: ;
    endcase
  end

  assign req_ready = (state == S_IDLE);
  assign want      = (state == S_RD);
  assign last      = (state == S_RD) && last_beat;

  p_pre_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd == C_PRE));
  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (cmd != C_PRE));
  p_len_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (cmd == C_NOP && req_ready));
endmodule

// File: rtl/sdbr_capture.sv
module sdbr_capture #(
  parameter int DQ_W    = 16,
  parameter int CAS_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want,
  input  logic            last,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data,
  output logic            done,
  output logic            fin
);
  logic [CAS_LAT-1:0] pw, pl;
  logic               last_q;

  generate
    if (CAS_LAT == 1) begin : g_short
      always_ff @(posedge clk) begin
        if (!rst_n) begin pw <= '0; pl <= '0; end
        else begin pw <= want; pl <= last; end
      end
    end else begin : g_long
      always_ff @(posedge clk) begin
        if (!rst_n) begin pw <= '0; pl <= '0; end
        else begin
          pw <= {pw[CAS_LAT-2:0], want};
          pl <= {pl[CAS_LAT-2:0], last};
        end
      end
    end
  endgenerate

  assign fin = rd_valid && last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_data <= '0; last_q <= 1'b0; done <= 1'b0;
    end else begin
      rd_valid <= pw[CAS_LAT-1];
      if (pw[CAS_LAT-1]) rd_data <= dq_in;
      last_q   <= pw[CAS_LAT-1] && pl[CAS_LAT-1];
      done     <= fin;
    end
  end

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_valid));
endmodule

// File: rtl/sdram_burst_reader.sv
module sdram_burst_reader
  import sdbr_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int ADDR_W  = 13,
  parameter int DQ_W    = 16,
  parameter int DQM_W   = 2,
  parameter int LEN_W   = 6,
  parameter int T_RP    = 2,
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        burst_sel,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  input  logic [DQ_W-1:0]   sd_dq_in,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              done
);
  sd_cmd_e cmd_w;
  logic    want_w, last_w, fin_w;

  sdbr_ctrl #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .T_RP(T_RP), .T_RCD(T_RCD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .burst_sel(burst_sel), .fin(fin_w), .req_ready(req_ready),
    .cmd(cmd_w), .ba(sd_ba), .addr(sd_addr), .want(want_w), .last(last_w)
  );

  sdbr_pins u_pins (
    .cmd(cmd_w), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n)
  );

  sdbr_capture #(.DQ_W(DQ_W), .CAS_LAT(CAS_LAT)) u_cap (
    .clk(clk), .rst_n(rst_n), .want(want_w), .last(last_w), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .fin(fin_w)
  );

  assign sd_cke = 1'b1;
  assign sd_dqm = req_ready ? {DQM_W{1'b1}} : {DQM_W{1'b0}};

  p_valid_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !req_ready);
  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

// File: tb/tb_sdram_burst_reader.sv
`timescale 1ns/1ps
module tb_sdram_burst_reader;
  localparam int TRP = 2, TRCD = 2, CL = 2;
  localparam int RS  = TRP + TRCD;      // first READ cycle
  localparam int DS  = RS + 1 + CL;     // first data cycle

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_bank = 0;
  logic [12:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic [5:0] req_len = 0;
  logic [1:0] burst_sel = 0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_ready, rd_valid, done;
  logic [1:0] sd_ba, sd_dqm;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq_in = 16'hDEAD, rd_data;

  int nerr = 0, nchk = 0, cyc = 0, edge_n = 0, cur_bl = 1;
  logic [15:0] sched_d [64];
  bit          sched_v [64];
  logic [12:0] act_row [4];

  always #2 clk = ~clk;

  sdram_burst_reader dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .burst_sel(burst_sel), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dqm(sd_dqm), .sd_dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done)
  );

  function automatic logic [15:0] mkdata(logic [1:0] b, logic [12:0] r, logic [9:0] c);
    return {b, r[5:0], c[7:0]};
  endfunction

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  // SDRAM model: command seen in cycle c is registered at edge c+1
  always @(posedge clk) edge_n <= edge_n + 1;
  always @(negedge clk) begin
    if (pins() == 4'b0011) act_row[sd_ba] = sd_addr;
    if (pins() == 4'b0101)
      for (int k = 0; k < cur_bl; k++) begin
        sched_v[(edge_n + 1 + CL + k) % 64] = 1'b1;
        sched_d[(edge_n + 1 + CL + k) % 64] =
          mkdata(sd_ba, act_row[sd_ba], sd_addr[9:0] + 10'(k));
      end
    sd_dq_in <= sched_v[(edge_n + 1) % 64] ? sched_d[(edge_n + 1) % 64] : 16'hDEAD;
    sched_v[(edge_n + 1) % 64] = 1'b0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got cycle %0d exp finish", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input string tag, input int k, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s cycle %0d: got %h exp %h", tag, k, got, exp);
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready", 0, req_ready, 1);
    chk("R1 cmd", 0, pins(), 4'b0111);
    chk("R1 valid", 0, rd_valid, 0);
    chk("R1 done", 0, done, 0);
    chk("R1 dqm", 0, sd_dqm, 2'b11);
    chk("R1 cke", 0, sd_cke, 1);
  endtask

  // R2: zero word count is ignored
  task automatic t_zero_len();
    @(negedge clk);
    req_bank = 2; req_row = 13'h55; req_col = 10'h10; req_len = 0; req_valid = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R2 zero-len cmd", k, pins(), 4'b0111);
      chk("R2 zero-len ready", k, req_ready, 1);
      chk("R2 zero-len dqm", k, sd_dqm, 2'b11);
    end
    req_valid = 0;
  endtask

  // R3..R9: one complete read transfer, optionally poked while busy (R2)
  task automatic t_read(input logic [1:0] b, input logic [12:0] r, input logic [9:0] c,
                        input int len, input logic [1:0] sel, input bit poke);
    int bl, reads, exp_reads;
    logic [3:0] ec;
    bl = 1 << sel; reads = 0; exp_reads = (len + bl - 1) / bl;
    @(negedge clk);
    chk("R2 ready before request", -1, req_ready, 1);
    req_bank = b; req_row = r; req_col = c; req_len = 6'(len); burst_sel = sel;
    req_valid = 1; cur_bl = bl;
    @(posedge clk);
    for (int k = 0; k < DS + len + 5; k++) begin
      @(negedge clk);
      if (k == 0 && !poke) req_valid = 0;
      if (k == 0 && poke) begin
        req_bank = ~b; req_row = ~r; req_col = ~c; req_len = 6'd7; burst_sel = ~sel;
      end
      if (k == 5) req_valid = 0;
      // command schedule
      if (k == 0) ec = 4'b0010;
      else if (k == TRP) ec = 4'b0011;
      else if (k >= RS && k < RS + len && ((k - RS) % bl) == 0) ec = 4'b0101;
      else ec = 4'b0111;
      chk((k >= RS) ? "R5 cmd" : "R3 cmd", k, pins(), ec);
      if (pins() == 4'b0101) reads++;
      if (ec == 4'b0010) begin
        chk("R3 pre A10", k, sd_addr[10], 1);
        chk("R3 pre bank", k, sd_ba, b);
      end
      if (ec == 4'b0011) begin
        chk("R3 act row", k, sd_addr, r);
        chk("R3 act bank", k, sd_ba, b);
      end
      if (ec == 4'b0101) begin
        chk("R5 read col", k, sd_addr, {3'b000, c + 10'(k - RS)});
        chk("R5 read bank", k, sd_ba, b);
      end
      // data
      if (k >= DS && k < DS + len) begin
        chk("R6 valid", k, rd_valid, 1);
        chk("R6 data", k, rd_data, mkdata(b, r, c + 10'(k - DS)));
      end else
        chk((k >= DS + len) ? "R7 surplus valid" : "R6 early valid", k, rd_valid, 0);
      chk("R8 done", k, done, (k == DS + len) ? 1 : 0);
      chk("R8 ready", k, req_ready, (k >= DS + len) ? 1 : 0);
      chk("R9 dqm", k, sd_dqm, (k >= DS + len) ? 2'b11 : 2'b00);
      chk("R9 cke", k, sd_cke, 1);
    end
    chk("R4 read count", 0, reads, exp_reads);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin sched_v[i] = 0; sched_d[i] = 0; end
    for (int i = 0; i < 4; i++) act_row[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();                                       // R1
    t_read(2'd1, 13'h0123, 10'h040, 4, 2'b11, 0);    // R4/R7: burst 8, surplus dropped
    t_read(2'd2, 13'h01A5, 10'h100, 4, 2'b01, 0);    // R5: READ NOP READ chain
    t_zero_len();                                    // R2
    t_read(2'd0, 13'h00FF, 10'h008, 4, 2'b10, 1);    // R2: poked while busy
    t_read(2'd3, 13'h1FFF, 10'h3F0, 3, 2'b00, 0);    // R4: burst 1
    t_read(2'd1, 13'h0A0A, 10'h020, 5, 2'b01, 0);    // R5/R7: 3 reads, 1 surplus
    t_read(2'd2, 13'h0777, 10'h080, 9, 2'b11, 1);    // R5: two burst-8 reads
    t_read(2'd0, 13'h0001, 10'h001, 1, 2'b11, 0);    // R6/R8: single word
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule